// File: doc/BRIEF.md
# LCD Video Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, a data-enable strobe, and the column and row of the current active pixel. The counters step once for each cycle in which the pixel-clock enable is high. The block runs from the system clock and does not generate the pixel clock.

Software programs the geometry through a small register window. There is a mode word for sync polarity and panel format, and four timing words that hold sync widths, porches and active size. All timing values take effect together at the next frame boundary.

A sticky start-of-frame flag drives an interrupt line through a mask. Separate write-one-to-set and write-one-to-clear addresses change the mask. The panel format field is only held and driven out to the pixel path; the block does no pixel formatting.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line runs in this order: horizontal sync, back porch, active, front porch. Field encodings, each storing length minus one: sync width at address 1 bits [15:0]; front porch at address 3 bits [15:0]; back porch at address 3 bits [31:16]; active width at address 4 bits [15:0]. The line length is the sum of the four lengths, and the timing words read back as written.
- R2: Each frame runs in this order: vertical sync lines, back porch lines, active lines, front porch lines. Sync line count minus one is at address 1 bits [31:16]. Front porch minus one is at address 2 bits [15:0]. The back porch is at address 2 bits [31:16] and is stored as the plain count, so zero is allowed. Active height minus one is at address 4 bits [31:16].
- R3: `de` is high only in active columns of active lines, and sync outputs are inactive while it is high. `pix_x` is the column within the active area and is 0 when `de` is low. `pix_y` is the row within the active lines and is 0 outside them.
- R4: Mode word (address 0) bit 0 set makes `hsync` active-low. Bit 1 set makes `vsync` active-low. When a bit is clear, that sync output is active-high.
- R5: `out_mode` shows mode word bits [9:8] (0 = 12-bit, 1 = 16-bit, 2 = 18-bit, 3 = 24-bit RGB). Address 0 reads back bits [9:8] and [1:0] as written.
- R6: When `pix_ce` is low, the counters and all timing outputs hold their values.
- R7: The status flag, read as bit 0 at address 8, is set on the pixel step that returns the counters to column 0, row 0. It stays set until a read of address 8 clears it. A new frame start in the same cycle as the read keeps the flag set.
- R8: Writing bit 0 = 1 to address 5 sets the interrupt mask. Writing bit 0 = 1 to address 6 clears it. Writing 0 to either address changes nothing. The mask reads back at address 7 bit 0. `sof_irq` is high only when both the flag and the mask are set.
- R9: Writes to the timing and mode words do not change the frame in progress. They take effect from the next frame start.
- R10: After reset, all registers, the mask and the flag are zero, and the counters are at column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable; one raster step per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (only side effect: clears status) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| hsync | output | 1 | Horizontal sync, polarity per mode word |
| vsync | output | 1 | Vertical sync, polarity per mode word |
| de | output | 1 | Data enable |
| pix_x | output | FIELD_W | Active column |
| pix_y | output | FIELD_W | Active row |
| out_mode | output | 2 | Panel format select |
| sof_irq | output | 1 | Start-of-frame interrupt |

## Verification
The properties assume at most one register access per cycle. They also assume every programmed field fits in FIELD_W bits, so the derived line and frame totals never wrap. The stimulus writes only small geometries, with fields in the low bits, and issues single-cycle bus accesses from tasks. `pix_ce` may follow any pattern; the stimulus holds it low for one stretch to exercise the hold behaviour.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_ce,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [FIELD_W-1:0] pix_x,
  output logic [FIELD_W-1:0] pix_y,
  output logic [1:0]         out_mode,
  output logic               sof_irq
);
  localparam int TW = FIELD_W + 3;
  localparam logic [3:0] A_MODE = 4'd0, A_SYNC = 4'd1, A_VPOR = 4'd2, A_HPOR = 4'd3,
                         A_SIZE = 4'd4, A_ISET = 4'd5, A_ICLR = 4'd6, A_MASK = 4'd7,
                         A_STAT = 4'd8;

  typedef logic [FIELD_W-1:0] fld_t;

  logic [1:0] fmt_q;
  logic       hpol_q, vpol_q;
  fld_t hsw_q, vsw_q, vfp_q, vbp_q, hfp_q, hbp_q, aw_q, ah_q;

  logic s_hpol, s_vpol;
  fld_t s_hsw, s_vsw, s_vfp, s_vbp, s_hfp, s_hbp, s_aw, s_ah;

  logic [TW-1:0] hcnt, vcnt;
  logic          sof_stat, irq_mask;

  function automatic logic [31:0] pack2(input fld_t lo, input fld_t hi);
    logic [31:0] w;
    w = '0;
    w[FIELD_W-1:0] = lo;
    w[16 +: FIELD_W] = hi;
    return w;
  endfunction

  wire [TW-1:0] h_se  = TW'(s_hsw) + TW'(1);
  wire [TW-1:0] h_as  = h_se + TW'(s_hbp) + TW'(1);
  wire [TW-1:0] h_ae  = h_as + TW'(s_aw) + TW'(1);
  wire [TW-1:0] h_tot = h_ae + TW'(s_hfp) + TW'(1);
  wire [TW-1:0] v_se  = TW'(s_vsw) + TW'(1);
  wire [TW-1:0] v_as  = v_se + TW'(s_vbp);
  wire [TW-1:0] v_ae  = v_as + TW'(s_ah) + TW'(1);
  wire [TW-1:0] v_tot = v_ae + TW'(s_vfp) + TW'(1);

  wire h_last    = (hcnt == h_tot - TW'(1));
  wire v_last    = (vcnt == v_tot - TW'(1));
  wire frame_end = pix_ce && h_last && v_last;

  wire wr_hit = reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '0; hpol_q <= 1'b0; vpol_q <= 1'b0;
      hsw_q <= '0; vsw_q <= '0; vfp_q <= '0; vbp_q <= '0;
      hfp_q <= '0; hbp_q <= '0; aw_q <= '0; ah_q <= '0;
      irq_mask <= 1'b0;
    end else if (wr_hit) begin
      case (reg_addr)
        A_MODE: begin
          fmt_q  <= reg_wdata[9:8];
          hpol_q <= reg_wdata[0];
          vpol_q <= reg_wdata[1];
        end
        A_SYNC: begin hsw_q <= reg_wdata[FIELD_W-1:0]; vsw_q <= reg_wdata[16 +: FIELD_W]; end
        A_VPOR: begin vfp_q <= reg_wdata[FIELD_W-1:0]; vbp_q <= reg_wdata[16 +: FIELD_W]; end
        A_HPOR: begin hfp_q <= reg_wdata[FIELD_W-1:0]; hbp_q <= reg_wdata[16 +: FIELD_W]; end
        A_SIZE: begin aw_q  <= reg_wdata[FIELD_W-1:0]; ah_q  <= reg_wdata[16 +: FIELD_W]; end
        A_ISET: if (reg_wdata[0]) irq_mask <= 1'b1;
        A_ICLR: if (reg_wdata[0]) irq_mask <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_hpol <= 1'b0; s_vpol <= 1'b0;
      s_hsw <= '0; s_vsw <= '0; s_vfp <= '0; s_vbp <= '0;
      s_hfp <= '0; s_hbp <= '0; s_aw <= '0; s_ah <= '0;
    end else if (frame_end) begin
      s_hpol <= hpol_q; s_vpol <= vpol_q;
      s_hsw <= hsw_q; s_vsw <= vsw_q; s_vfp <= vfp_q; s_vbp <= vbp_q;
      s_hfp <= hfp_q; s_hbp <= hbp_q; s_aw <= aw_q; s_ah <= ah_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_ce) begin
      if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + TW'(1);
      end else begin
        hcnt <= hcnt + TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               sof_stat <= 1'b0;
    else if (frame_end)                       sof_stat <= 1'b1;
    else if (reg_re && reg_addr == A_STAT)    sof_stat <= 1'b0;
  end

  wire h_act = (hcnt >= h_as) && (hcnt < h_ae);
  wire v_act = (vcnt >= v_as) && (vcnt < v_ae);
  wire [TW-1:0] x_off = hcnt - h_as;
  wire [TW-1:0] y_off = vcnt - v_as;

  assign hsync    = (hcnt < h_se) ^ s_hpol;
  assign vsync    = (vcnt < v_se) ^ s_vpol;
  assign de       = h_act && v_act;
  assign pix_x    = de ? x_off[FIELD_W-1:0] : '0;
  assign pix_y    = v_act ? y_off[FIELD_W-1:0] : '0;
  assign out_mode = fmt_q;
  assign sof_irq  = sof_stat && irq_mask;

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {22'd0, fmt_q, 6'd0, vpol_q, hpol_q};
      A_SYNC:  reg_rdata = pack2(hsw_q, vsw_q);
      A_VPOR:  reg_rdata = pack2(vfp_q, vbp_q);
      A_HPOR:  reg_rdata = pack2(hfp_q, hbp_q);
      A_SIZE:  reg_rdata = pack2(aw_q, ah_q);
      A_MASK:  reg_rdata = {31'd0, irq_mask};
      A_STAT:  reg_rdata = {31'd0, sof_stat};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcd_timing_gen_sva.sv
module lcd_timing_gen_sva #(
  parameter int TW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [TW-1:0] hcnt,
  input logic [TW-1:0] vcnt,
  input logic [TW-1:0] h_tot,
  input logic [TW-1:0] v_tot,
  input logic          sof_stat,
  input logic          s_hpol,
  input logic          s_vpol,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          sof_irq
);
  assert_hcnt_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < h_tot);

  assert_vcnt_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < v_tot);

  assert_sync_idle_in_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == s_hpol) && (vsync == s_vpol));

  assert_hold_without_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable(hcnt) && $stable(vcnt));

  assert_flag_rises_at_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_stat) |-> (hcnt == '0) && (vcnt == '0));

  assert_disable_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd6 && reg_wdata[0]) |=> !sof_irq);
endmodule

bind lcd_timing_gen lcd_timing_gen_sva #(.TW(TW)) sva_i (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hcnt(hcnt), .vcnt(vcnt),
  .h_tot(h_tot), .v_tot(v_tot), .sof_stat(sof_stat), .s_hpol(s_hpol),
  .s_vpol(s_vpol), .hsync(hsync), .vsync(vsync), .de(de), .sof_irq(sof_irq)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_ce = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic hsync, vsync, de, sof_irq;
  logic [CW-1:0] pix_x, pix_y;
  logic [1:0] out_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_timing_gen #(.FIELD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .out_mode(out_mode), .sof_irq(sof_irq)
  );

  // mode, word1, word2, word3, word4, line length, frame lines, de count
  localparam logic [31:0] VEC [4][8] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0002_0000, 32'h0002_0001, 32'h0003_0007, 32'd15, 32'd8,  32'd32},
    '{32'h0000_0203, 32'h0001_0000, 32'h0000_0001, 32'h0000_0002, 32'h0002_0004, 32'd10, 32'd7,  32'd15},
    '{32'h0000_0301, 32'h0000_0002, 32'h0001_0002, 32'h0001_0000, 32'h0004_0005, 32'd12, 32'd10, 32'd30},
    '{32'h0000_0102, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'd4,  32'd3,  32'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wait_sof();
    while (!sof_irq) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int cnt;
    logic [CW-1:0] hx, hy;
    logic hh, hv, hd;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state: counters at origin, default geometry, active-high syncs
    chk("R10 hsync after reset", hsync, 1);
    chk("R10 vsync after reset", vsync, 1);
    chk("R10 de after reset", de, 0);
    chk("R10 irq after reset", sof_irq, 0);
    chk("R10 out_mode after reset", out_mode, 0);
    rd(4'd8, d); chk("R10 status after reset", d, 0);
    rd(4'd7, d); chk("R10 mask after reset", d, 0);
    rd(4'd0, d); chk("R10 mode word after reset", d, 0);

    // R8 masked flag does not reach irq; R7 sticky flag and read-clear
    repeat (30) @(negedge clk);
    chk("R8 irq low while masked", sof_irq, 0);
    rd(4'd8, d); chk("R7 flag set after frame start", d, 1);
    rd(4'd8, d); chk("R7 flag cleared by read", d, 0);

    wr(4'd5, 32'd1);
    rd(4'd7, d); chk("R8 mask set by enable write", d, 1);
    wr(4'd6, 32'd0);
    rd(4'd7, d); chk("R8 zero to disable has no effect", d, 1);

    // table walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < 4; i++) begin
      int hsw, hbp, aw, vsw, vbp, ah, hp, vp;
      int e_hs, e_vs, e_de, e_x, e_y, dec;
      hsw = int'(VEC[i][1][15:0]) + 1;  vsw = int'(VEC[i][1][31:16]) + 1;
      vbp = int'(VEC[i][2][31:16]);
      hbp = int'(VEC[i][3][31:16]) + 1;
      aw  = int'(VEC[i][4][15:0]) + 1;  ah  = int'(VEC[i][4][31:16]) + 1;
      hp  = int'(VEC[i][0][0]);         vp  = int'(VEC[i][0][1]);
      for (int r = 0; r < 5; r++) wr(4'(r), VEC[i][r]);
      rd(4'd0, d); chk("R5 mode word readback", d, VEC[i][0]);
      rd(4'd1, d); chk("R1 timing word readback", d, VEC[i][1]);
      rd(4'd4, d); chk("R2 size word readback", d, VEC[i][4]);
      chk("R5 out_mode from mode bits", out_mode, int'(VEC[i][0][9:8]));
      rd(4'd8, d);
      wait_sof();
      e_hs = 0; e_vs = 0; e_de = 0; e_x = 0; e_y = 0; dec = 0;
      for (int f = 0; f < 2; f++)
        for (int v = 0; v < int'(VEC[i][6]); v++)
          for (int h = 0; h < int'(VEC[i][5]); h++) begin
            bit ha, va, hact, vact, ede;
            ha = h < hsw; va = v < vsw;
            hact = (h >= hsw + hbp) && (h < hsw + hbp + aw);
            vact = (v >= vsw + vbp) && (v < vsw + vbp + ah);
            ede = hact && vact;
            if (hsync != (ha ^ hp[0])) e_hs++;
            if (vsync != (va ^ vp[0])) e_vs++;
            if (de != ede) e_de++;
            if (int'(pix_x) != (ede ? h - (hsw + hbp) : 0)) e_x++;
            if (int'(pix_y) != (vact ? v - (vsw + vbp) : 0)) e_y++;
            if (de) dec++;
            @(negedge clk);
          end
      chk("R1 R4 hsync pattern mismatches", e_hs, 0);
      chk("R2 R4 vsync pattern mismatches", e_vs, 0);
      chk("R3 de pattern mismatches", e_de, 0);
      chk("R3 pix_x mismatches", e_x, 0);
      chk("R3 pix_y mismatches", e_y, 0);
      chk("R3 de count per frame", dec / 2, int'(VEC[i][7]));
    end

    // R9: mid-frame write to size word must wait for the next frame
    rd(4'd8, d);
    wr(4'd4, 32'h0001_0001);
    cnt = 0;
    while (!sof_irq) begin if (de) cnt++; @(negedge clk); end
    chk("R9 old size kept for current frame", cnt, 1);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin if (de) cnt++; @(negedge clk); end
    chk("R9 new size used from next frame", cnt, 4);

    // R6: hold with pix_ce low
    repeat (3) @(negedge clk);
    pix_ce = 1'b0;
    @(negedge clk);
    hx = pix_x; hy = pix_y; hh = hsync; hv = vsync; hd = de;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pix_x != hx || pix_y != hy || hsync != hh || vsync != hv || de != hd) cnt++;
    end
    chk("R6 outputs held without pix_ce", cnt, 0);
    pix_ce = 1'b1;

    // R8: disable write drops irq, flag stays sticky
    wait_sof();
    chk("R8 irq high with flag and mask", sof_irq, 1);
    wr(4'd6, 32'd1);
    chk("R8 irq low after disable", sof_irq, 0);
    rd(4'd7, d); chk("R8 mask cleared", d, 0);
    rd(4'd8, d); chk("R7 flag unaffected by mask", d, 1);
    wr(4'd5, 32'd0);
    rd(4'd7, d); chk("R8 zero to enable has no effect", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule